// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This block connects a 32-bit register datapath to a data memory organised in words. It handles four memory operations: word load, word store, byte load and byte store. Each request carries a base register value and a signed 16-bit displacement. The block adds them to form a byte address. It splits that address into a word index for the memory and a byte lane within the word. Lanes are numbered big-endian, so the byte at the lowest address sits in the most significant bits of the word.

On the store side, the block drives the memory write strobe and a per-lane byte-enable mask. A byte store places its data in every lane, and the mask picks the one lane that is written. On the load side, the memory answers one cycle after the request. The block then returns either the whole word or the selected byte, sign-extended to 32 bits, together with a valid strobe.

A word access whose address is not a multiple of four is flagged and never reaches the memory.

Top module: `lsu_lane_top`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` sign-extended from 16 to 32 bits, wrapping modulo 2^32. `mem_addr` carries bits 31..2 of that address in the same cycle as the request.
- R2: The opcodes are decoded as follows: 35 is a word load, 43 a word store, 32 a byte load and 40 a byte store. Any other opcode asserts no read, no write and no misalign flag.
- R3: A word load asserts `mem_rd_en` in the request cycle. In the next cycle, `ld_valid` is 1 and `ld_data` equals `mem_rdata` unchanged.
- R4: A byte load picks one lane by address bits 1..0: lane 0 is `mem_rdata[31:24]`, lane 1 is `[23:16]`, lane 2 is `[15:8]` and lane 3 is `[7:0]`. The picked byte appears in `ld_data[7:0]` on the cycle after the request.
- R5: For a byte load, `ld_data[31:8]` is filled with copies of bit 7 of the picked byte.
- R6: An aligned word store asserts `mem_wr_en` and sets `mem_be` to 4'b1111. `mem_wdata` equals `req_wdata`. Bit i of `mem_be` covers `mem_wdata[8i+7:8i]`.
- R7: A byte store asserts `mem_wr_en` and sets exactly one `mem_be` bit. Lane 0 sets bit 3, lane 1 sets bit 2, lane 2 sets bit 1 and lane 3 sets bit 0. `mem_wdata` holds `req_wdata[7:0]` in all four bytes, and so does it for a byte load.
- R8: For a word load or store with address bits 1..0 not equal to 00, `misalign` is raised and `mem_rd_en`, `mem_wr_en` and `mem_be` stay 0. No load result follows. Byte accesses never raise `misalign`.
- R9: `ld_valid` is 1 only in the cycle right after an accepted load. It is 0 during and after a synchronous reset, and a load that is issued in a reset cycle is dropped. `ld_data` is 0 whenever `ld_valid` is 0.
- R10: With `req_valid` low, `mem_rd_en`, `mem_wr_en`, `mem_be` and `misalign` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 30 | Word index to memory |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-enable mask, bit 3 = most significant byte |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data, valid one cycle after the read strobe |
| misalign | output | 1 | Misaligned word access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
The hardest case to reach is two loads issued back to back. In that case the memory is returning data for the first load while the second load's address, with a different lane and size, is already on the inputs. A fault that takes the lane or size from the live request instead of the captured one only shows up then. The stimulus covers it with a directed sequence: a byte load on lane 2 is followed at once by a word load. That sequence is followed by a load issued in a reset cycle, which must produce no result.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam logic [5:0] OPC_LDW = 6'd35;
    localparam logic [5:0] OPC_STW = 6'd43;
    localparam logic [5:0] OPC_LDB = 6'd32;
    localparam logic [5:0] OPC_STB = 6'd40;

    typedef struct packed {
        logic load;
        logic store;
        logic byte_sz;
    } op_kind_t;

    function automatic op_kind_t decode_op(logic [5:0] opc);
        op_kind_t k;
        k = '0;
        case (opc)
            OPC_LDW: k.load  = 1'b1;
            OPC_STW: k.store = 1'b1;
            OPC_LDB: begin k.load  = 1'b1; k.byte_sz = 1'b1; end
            OPC_STB: begin k.store = 1'b1; k.byte_sz = 1'b1; end
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int WADR_W = DATA_W - LANE_W
) (
    input  logic [DATA_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [WADR_W-1:0] word_addr,
    output logic [LANE_W-1:0] lane
);
    logic [DATA_W-1:0] off_ext;
    logic [DATA_W-1:0] eff;

    always_comb begin
        off_ext   = {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
        eff       = base + off_ext;
        word_addr = eff[DATA_W-1:LANE_W];
        lane      = eff[LANE_W-1:0];
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_en,
    input  logic              byte_sz,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // big-endian: lane k drives the k-th byte from the top
        assign be[LANES-1-k] = st_en & (~byte_sz | (lane == LANE_W'(k)));
        assign wdata[8*k +: 8] = byte_sz ? src[7:0] : src[8*k +: 8];
    end

    // R7: a byte store enables one lane only
    a_r7_byte_single_lane: assert property (@(posedge clk) disable iff (rst)
        (st_en && byte_sz) |-> ($countones(be) == 1));

    // R6: a word store enables every lane
    a_r6_word_full_mask: assert property (@(posedge clk) disable iff (rst)
        (st_en && !byte_sz) |-> (&be));
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              byte_sz,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] rdata,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    logic              pend_byte;
    logic [LANE_W-1:0] pend_lane;
    logic [7:0]        lane_bytes [LANES];
    logic [7:0]        picked;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid     <= 1'b0;
            pend_byte <= 1'b0;
            pend_lane <= '0;
        end else begin
            valid <= issue;
            if (issue) begin
                pend_byte <= byte_sz;
                pend_lane <= lane;
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_pick
        assign lane_bytes[k] = rdata[DATA_W-1-8*k -: 8];
    end

    always_comb begin
        picked = lane_bytes[pend_lane];
        if (!valid)
            data = '0;
        else if (pend_byte)
            data = {{(DATA_W-8){picked[7]}}, picked};
        else
            data = rdata;
    end

    // R9: every accepted load yields a result on the next cycle
    a_r9_result_follows_issue: assert property (@(posedge clk) disable iff (rst)
        issue |=> valid);

    // R9: a result always has a load one cycle before it
    a_r9_result_has_cause: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(issue));

    // R5: a negative byte fills the upper bits with ones
    a_r5_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (valid && pend_byte && data[7]) |-> (&data[DATA_W-1:8]));
endmodule

// File: rtl/lsu_lane_top.sv
module lsu_lane_top
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int WADR_W = DATA_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [5:0]        req_opcode,
    input  logic [DATA_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [WADR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              misalign,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    op_kind_t          kind;
    logic [LANE_W-1:0] lane;

    lsu_addr_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) addr_i (
        .base      (req_base),
        .offset    (req_offset),
        .word_addr (mem_addr),
        .lane      (lane)
    );

    always_comb begin
        kind      = decode_op(req_opcode);
        misalign  = req_valid & (kind.load | kind.store) & ~kind.byte_sz & (|lane);
        mem_rd_en = req_valid & kind.load  & ~misalign;
        mem_wr_en = req_valid & kind.store & ~misalign;
    end

    lsu_store_lane #(.DATA_W(DATA_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .st_en   (mem_wr_en),
        .byte_sz (kind.byte_sz),
        .lane    (lane),
        .src     (req_wdata),
        .be      (mem_be),
        .wdata   (mem_wdata)
    );

    lsu_load_align #(.DATA_W(DATA_W)) load_i (
        .clk     (clk),
        .rst     (rst),
        .issue   (mem_rd_en),
        .byte_sz (kind.byte_sz),
        .lane    (lane),
        .rdata   (mem_rdata),
        .valid   (ld_valid),
        .data    (ld_data)
    );

    // R8: a flagged access reaches neither memory strobe
    a_r8_misalign_blocks: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (!mem_rd_en && !mem_wr_en && (mem_be == '0)));

    // R10: no request, no memory activity
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!mem_rd_en && !mem_wr_en && !misalign && (mem_be == '0)));
endmodule

// File: tb/lsu_lane_top_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_top_tb_top;

    localparam real CLK_NS  = 4.0;
    localparam int  NVEC    = 16;
    localparam int  WD_CYC  = 200000;

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] src;
        logic [31:0] rdata;
        logic [31:0] e_addr;
        logic [3:0]  e_be;
        logic [31:0] e_wdata;
        logic        e_wr;
        logic        e_rd;
        logic        e_mis;
        logic        e_ldv;
        logic [31:0] e_ld;
    } vec_t;

    // opcodes: 35 word load, 43 word store, 32 byte load, 40 byte store
    localparam vec_t VECS [NVEC] = '{
        // R1 R3: positive displacement word load
        '{6'd35, 32'h12004094, 16'h0018, 32'h0, 32'hDEADBEEF, 32'h0480102B, 4'h0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'hDEADBEEF},
        // R1 R3: negative displacement
        '{6'd35, 32'h00001000, 16'hFFFC, 32'h0, 32'h01234567, 32'h000003FF, 4'h0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'h01234567},
        // R4 R5: lanes 0..3, negative and positive bytes
        '{6'd32, 32'h00000100, 16'h0000, 32'h0, 32'h8A112233, 32'h00000040, 4'h0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFFFF8A},
        '{6'd32, 32'h00000100, 16'h0001, 32'h0, 32'h8A7F2233, 32'h00000040, 4'h0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'h0000007F},
        '{6'd32, 32'h00000100, 16'h0002, 32'h0, 32'h0000C300, 32'h00000040, 4'h0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFFFFC3},
        '{6'd32, 32'h00000100, 16'h0003, 32'h0, 32'h00000045, 32'h00000040, 4'h0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'h00000045},
        // R1 R4: wrap below zero, lane 3
        '{6'd32, 32'h00000000, 16'hFFFF, 32'h0, 32'h000000F0, 32'h3FFFFFFF, 4'h0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFFFFF0},
        // R6: aligned word store
        '{6'd43, 32'h00002000, 16'h0008, 32'hCAFEF00D, 32'h0, 32'h00000802, 4'hF, 32'hCAFEF00D, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
        // R7: byte store, each lane
        '{6'd40, 32'h00002000, 16'h0004, 32'h123456AB, 32'h0, 32'h00000801, 4'h8, 32'hABABABAB, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
        '{6'd40, 32'h00002000, 16'h0005, 32'h123456AB, 32'h0, 32'h00000801, 4'h4, 32'hABABABAB, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
        '{6'd40, 32'h00002000, 16'h0006, 32'h123456AB, 32'h0, 32'h00000801, 4'h2, 32'hABABABAB, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
        '{6'd40, 32'h00002000, 16'h0007, 32'hFFFFFF00, 32'h0, 32'h00000801, 4'h1, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
        // R8: misaligned word store and load
        '{6'd43, 32'h00002000, 16'h0002, 32'hCAFEF00D, 32'h0, 32'h00000800, 4'h0, 32'hCAFEF00D, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
        '{6'd35, 32'h00002000, 16'h0001, 32'h0, 32'hFFFFFFFF, 32'h00000800, 4'h0, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
        // R2: unknown opcode does nothing
        '{6'd4,  32'h00002000, 16'h0000, 32'h55AA55AA, 32'hFFFFFFFF, 32'h00000800, 4'h0, 32'h55AA55AA, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        // R1 R6: most negative displacement
        '{6'd43, 32'h00000010, 16'h8000, 32'h00C0FFEE, 32'h0, 32'h3FFFE004, 4'hF, 32'h00C0FFEE, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  req_opcode = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [29:0] mem_addr;
    logic        mem_rd_en, mem_wr_en, misalign, ld_valid;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, ld_data;
    logic [31:0] mem_rdata = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    lsu_lane_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [5:0] op, logic [31:0] b, logic [15:0] o, logic [31:0] s);
        req_valid  = v;
        req_opcode = op;
        req_base   = b;
        req_offset = o;
        req_wdata  = s;
    endtask

    initial begin
        // R9: reset state
        drive(1'b0, 6'd35, 32'h0, 16'h0, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset ld_valid", {31'b0, ld_valid}, 32'h0);
        chk("R9 reset ld_data", ld_data, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R10: idle request with a store opcode present
        @(negedge clk);
        drive(1'b0, 6'd43, 32'h2000, 16'h0, 32'hFFFFFFFF);
        #1;
        chk("R10 idle wr_en", {31'b0, mem_wr_en}, 32'h0);
        chk("R10 idle be", {28'b0, mem_be}, 32'h0);
        chk("R10 idle misalign", {31'b0, misalign}, 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(1'b1, VECS[i].op, VECS[i].base, VECS[i].off, VECS[i].src);
            #1;
            chk($sformatf("R1 v%0d addr", i), {2'b0, mem_addr}, VECS[i].e_addr);
            chk($sformatf("R6 R7 v%0d be", i), {28'b0, mem_be}, {28'b0, VECS[i].e_be});
            chk($sformatf("R6 R7 v%0d wdata", i), mem_wdata, VECS[i].e_wdata);
            chk($sformatf("R2 v%0d wr_en", i), {31'b0, mem_wr_en}, {31'b0, VECS[i].e_wr});
            chk($sformatf("R2 v%0d rd_en", i), {31'b0, mem_rd_en}, {31'b0, VECS[i].e_rd});
            chk($sformatf("R8 v%0d misalign", i), {31'b0, misalign}, {31'b0, VECS[i].e_mis});
            @(negedge clk);
            drive(1'b0, 6'd0, 32'h0, 16'h0, 32'h0);
            mem_rdata = VECS[i].rdata;
            #1;
            chk($sformatf("R9 v%0d ld_valid", i), {31'b0, ld_valid}, {31'b0, VECS[i].e_ldv});
            chk($sformatf("R3 R4 R5 v%0d ld_data", i), ld_data, VECS[i].e_ld);
        end

        // back-to-back loads: byte lane 2 then word
        @(negedge clk);
        drive(1'b1, 6'd32, 32'h100, 16'h0002, 32'h0);
        @(negedge clk);
        drive(1'b1, 6'd35, 32'h1000, 16'h0000, 32'h0);
        mem_rdata = 32'h00009900;
        #1;
        chk("R4 R5 b2b first ld_valid", {31'b0, ld_valid}, 32'h1);
        chk("R4 R5 b2b first ld_data", ld_data, 32'hFFFFFF99);
        @(negedge clk);
        drive(1'b0, 6'd0, 32'h0, 16'h0, 32'h0);
        mem_rdata = 32'h13579BDF;
        #1;
        chk("R3 b2b second ld_data", ld_data, 32'h13579BDF);
        @(negedge clk);
        #1;
        chk("R9 b2b drained ld_valid", {31'b0, ld_valid}, 32'h0);
        chk("R9 b2b drained ld_data", ld_data, 32'h0);

        // R9: load issued in a reset cycle is dropped
        @(negedge clk);
        drive(1'b1, 6'd35, 32'h1000, 16'h0, 32'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 6'd0, 32'h0, 16'h0, 32'h0);
        mem_rdata = 32'hA5A5A5A5;
        #1;
        chk("R9 reset drops load", {31'b0, ld_valid}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule